// File: doc/BRIEF.md
# Prime-Field Adder-Subtractor, Modulus 2^255 - 19

This block adds or subtracts two elements of the prime field with modulus p = 2^255 - 19. Each operand arrives as fifteen 17-bit limbs packed into one 255-bit word. The block returns the fully reduced result. A new operation may enter on every clock, and each result appears a fixed three cycles later.

Each operation carries an opaque tag. The tag comes back unchanged beside its result, so a caller that interleaves several independent contexts can route each answer home. The stream has no ready signal because the pipeline never stalls.

Internally there are three registered steps. The first step forms the raw limb sum. For subtraction it forms the difference biased by 2p, so the value never goes negative. The second step folds every weight of 2^255 back in as 19. The third step subtracts p once when the folded value is not below p.

Top module: `fieldAddSub`

## Requirements
- R1: Operand and result words hold fifteen 17-bit limbs, least significant limb first. Limb i occupies bits [17i+16:17i], and the word's value is the sum of limb_i * 2^(17i). Carries between limbs are honoured in both directions.
- R2: With `inSub` low the result is (a + b) mod p. With `inSub` high the result is (a - b) mod p. Both operands are canonical.
- R3: Every delivered result lies in [0, p).
- R4: An operation sampled with `inValid` high at clock edge k is delivered with `outValid` high at edge k+3.
- R5: Operations may be presented on consecutive cycles (initiation interval 1), and each one gets its own correct result.
- R6: `outTag` equals the `inTag` that was sampled with the operation whose result is on `outData`.
- R7: `outValid` is high only three cycles after an accepted operation. Idle cycles, or bubbles, on the input appear as low `outValid` cycles in the same positions.
- R8: While `rst` is high, `outValid` is low on the next cycle. Operations presented during reset, or still in flight when reset arrives, never produce an output.
- R9: A result whose exact value equals p, or 2^255, wraps to its reduced value: 0 for a+b = p or a-a, and 19 for 2^255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Operation present this cycle |
| inSub | input | 1 | 1 = subtract, 0 = add |
| inTag | input | 6 | Opaque context tag |
| inA | input | 255 | First operand, fifteen 17-bit limbs, limb 0 at LSB |
| inB | input | 255 | Second operand, same layout |
| outValid | output | 1 | Result present this cycle |
| outTag | output | 6 | Tag of the returned result |
| outData | output | 255 | Canonical result, same limb layout |

## Verification
Every result is due exactly three rising edges after the edge that sampled its operands. The bench drives inputs on falling edges and reads the result on the third falling edge after driving. At that point it checks valid, tag and data together.

Two directed sequences check the neighbouring cycles. The first is an isolated operation with valid sampled on falling edges one through four, so an off-by-one latency is seen. The second is a bubble pattern whose output valid must repeat the input pattern shifted by three. A reset landing mid-flight is checked at the exact cycle where the dropped result would otherwise have appeared.

// File: rtl/fieldAddPkg.sv
package fieldAddPkg;

  localparam int FE_LIMB_W     = 17;
  localparam int FE_NUM_LIMBS  = 15;
  localparam int FE_FOLD_K     = 19;  // 2^255 mod p
  localparam int FE_PIPE_DEPTH = 3;

  // strobes from control to datapath: stage capture enables and op select
  typedef struct packed {
    logic en1;
    logic en2;
    logic en3;
    logic subSel;
  } stageStrobeT;

endpackage

// File: rtl/fieldLimbChain.sv
// Three-operand limb adder with a ripple of small carries between limbs.
module fieldLimbChain #(
  parameter int LIMB_W    = 17,
  parameter int NUM_LIMBS = 15
) (
  input  logic [LIMB_W*NUM_LIMBS-1:0] opA,
  input  logic [LIMB_W*NUM_LIMBS-1:0] opB,
  input  logic [LIMB_W*NUM_LIMBS-1:0] opC,
  output logic [LIMB_W*NUM_LIMBS-1:0] sumOut,
  output logic [1:0]                  carryOut
);

  localparam int SUM_W = LIMB_W + 2;

  logic [NUM_LIMBS:0][1:0] carry;
  assign carry[0] = 2'b00;

  for (genvar i = 0; i < NUM_LIMBS; i++) begin : g_limb
    logic [SUM_W-1:0] limbSum;
    assign limbSum = {2'b00, opA[i*LIMB_W +: LIMB_W]}
                   + {2'b00, opB[i*LIMB_W +: LIMB_W]}
                   + {2'b00, opC[i*LIMB_W +: LIMB_W]}
                   + {{LIMB_W{1'b0}}, carry[i]};
    assign sumOut[i*LIMB_W +: LIMB_W] = limbSum[LIMB_W-1:0];
    assign carry[i+1] = limbSum[SUM_W-1:LIMB_W];
  end

  assign carryOut = carry[NUM_LIMBS];

endmodule

// File: rtl/fieldAddControl.sv
// Valid and tag shift register; issues per-stage strobes to the datapath.
module fieldAddControl
  import fieldAddPkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inSub,
  input  logic [TAG_W-1:0] inTag,
  output stageStrobeT      stb,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag
);

  localparam int DEPTH = FE_PIPE_DEPTH;

  logic [DEPTH-1:0] validPipe;
  logic [TAG_W-1:0] tagPipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[DEPTH-2:0], inValid};
    end
  end

  always_ff @(posedge clk) begin
    tagPipe[0] <= inTag;
    for (int s = 1; s < DEPTH; s++) begin
      tagPipe[s] <= tagPipe[s-1];
    end
  end

  always_comb begin
    stb.en1    = inValid;
    stb.en2    = validPipe[0];
    stb.en3    = validPipe[1];
    stb.subSel = inSub;
  end

  assign outValid = validPipe[DEPTH-1];
  assign outTag   = tagPipe[DEPTH-1];

  AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##2 outValid); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3)); // R7
  AST_TAG_CARRY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outTag == $past(inTag, 3))); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !outValid); // R8

endmodule

// File: rtl/fieldAddDatapath.sv
// Three registered steps: biased raw sum, fold of 2^255 weights, final -p.
module fieldAddDatapath
  import fieldAddPkg::*;
#(
  parameter int LIMB_W    = FE_LIMB_W,
  parameter int NUM_LIMBS = FE_NUM_LIMBS,
  parameter int FOLD_K    = FE_FOLD_K
) (
  input  logic                        clk,
  input  logic                        rst,
  input  stageStrobeT                 stb,
  input  logic [LIMB_W*NUM_LIMBS-1:0] inA,
  input  logic [LIMB_W*NUM_LIMBS-1:0] inB,
  output logic [LIMB_W*NUM_LIMBS-1:0] outData
);

  localparam int W = LIMB_W * NUM_LIMBS;
  // p = 2^W - K
  localparam logic [W-1:0] P_VAL    = {W{1'b1}} - W'(FOLD_K - 1);
  // a + 2p - b = a + ~b + (2^W - (2K-1)) - 2^W*... folded into this bias
  localparam logic [W-1:0] SUB_BIAS = {W{1'b1}} - W'(2*FOLD_K - 2);
  localparam logic [W-1:0] FOLD_VEC = W'(FOLD_K);

  // ---------- step 1: raw sum or biased difference ----------
  logic [W-1:0] bOperand, biasVec, s1LoNext;
  logic [1:0]   s1HiNext;
  logic [W-1:0] s1Lo;
  logic [1:0]   s1Hi;

  assign bOperand = stb.subSel ? ~inB : inB;
  assign biasVec  = stb.subSel ? SUB_BIAS : '0;

  fieldLimbChain #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_rawChain (
    .opA(inA), .opB(bOperand), .opC(biasVec),
    .sumOut(s1LoNext), .carryOut(s1HiNext)
  );

  always_ff @(posedge clk) begin
    if (stb.en1) begin
      s1Lo <= s1LoNext;
      s1Hi <= s1HiNext;
    end
  end

  // ---------- step 2: fold bits at weight 2^W back in as K ----------
  logic [W-1:0] foldAdd, s2LoNext;
  logic [1:0]   s2HiNext;
  logic [W-1:0] s2Lo;
  logic [1:0]   s2Hi;

  assign foldAdd = W'(s1Hi) * W'(FOLD_K);

  fieldLimbChain #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_foldChain (
    .opA(s1Lo), .opB('0), .opC(foldAdd),
    .sumOut(s2LoNext), .carryOut(s2HiNext)
  );

  always_ff @(posedge clk) begin
    if (stb.en2) begin
      s2Lo <= s2LoNext;
      s2Hi <= s2HiNext;
    end
  end

  // ---------- step 3: one conditional subtraction of p ----------
  // v >= p  <=>  v + K reaches 2^W; then v - p is the low W bits of v + K
  logic [W-1:0] trialLo, resultNext;
  logic [1:0]   trialCarry;
  logic         atLeastP;

  fieldLimbChain #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS)) u_trialChain (
    .opA(s2Lo), .opB('0), .opC(FOLD_VEC),
    .sumOut(trialLo), .carryOut(trialCarry)
  );

  assign atLeastP   = (s2Hi != 2'b00) || (trialCarry != 2'b00);
  assign resultNext = atLeastP ? trialLo : s2Lo;

  always_ff @(posedge clk) begin
    if (stb.en3) begin
      outData <= resultNext;
    end
  end

  AST_RAW_RANGE: assert property (@(posedge clk) disable iff (rst)
    stb.en1 |=> (s1Hi != 2'b11)); // R2
  AST_FOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    stb.en2 |=> ((s2Hi == 2'b00) || (s2Hi == 2'b01 && s2Lo < W'(2*FOLD_K)))); // R3
  AST_CANONICAL: assert property (@(posedge clk) disable iff (rst)
    stb.en3 |=> (outData < P_VAL)); // R3

endmodule

// File: rtl/fieldAddSub.sv
module fieldAddSub
  import fieldAddPkg::*;
#(
  parameter int LIMB_W    = FE_LIMB_W,
  parameter int NUM_LIMBS = FE_NUM_LIMBS,
  parameter int TAG_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic                        inSub,
  input  logic [TAG_W-1:0]            inTag,
  input  logic [LIMB_W*NUM_LIMBS-1:0] inA,
  input  logic [LIMB_W*NUM_LIMBS-1:0] inB,
  output logic                        outValid,
  output logic [TAG_W-1:0]            outTag,
  output logic [LIMB_W*NUM_LIMBS-1:0] outData
);

  stageStrobeT stb;

  fieldAddControl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSub(inSub), .inTag(inTag),
    .stb(stb), .outValid(outValid), .outTag(outTag)
  );

  fieldAddDatapath #(.LIMB_W(LIMB_W), .NUM_LIMBS(NUM_LIMBS), .FOLD_K(FE_FOLD_K)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .inA(inA), .inB(inB), .outData(outData)
  );

endmodule

// File: tb/fieldAddSub_tb.sv
`timescale 1ns/1ps
module fieldAddSub_tb;

  localparam int TAG_W = 6;
  localparam int NV    = 12;
  localparam logic [254:0] P = {255{1'b1}} - 255'd18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inSub = 1'b0;
  logic [TAG_W-1:0] inTag = '0;
  logic [254:0] inA = '0, inB = '0;
  logic outValid;
  logic [TAG_W-1:0] outTag;
  logic [254:0] outData;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fieldAddSub #(.TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSub(inSub), .inTag(inTag),
    .inA(inA), .inB(inB), .outValid(outValid), .outTag(outTag), .outData(outData)
  );

  // stimulus table: operand a, operand b, subtract select
  localparam logic [254:0] VEC_A [NV] = '{
    255'd5, P - 255'd1, P - 255'd1, P - 255'd1, 255'h1FFFF, 255'd1 << 17,
    255'd100, 255'd0, 255'd0, P - 255'd5, 255'd1 << 254, {15{17'h1A5C3}}};
  localparam logic [254:0] VEC_B [NV] = '{
    255'd7, 255'd1, P - 255'd1, 255'd19, 255'd1, 255'd1,
    255'd30, 255'd1, P - 255'd1, P - 255'd5, 255'd1 << 254, {15{17'h0F0F1}}};
  localparam logic VEC_SUB [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  // reference from R2: plain modular arithmetic on wide integers
  function automatic logic [254:0] refOp(input logic [254:0] a, input logic [254:0] b,
                                         input logic sub);
    logic [256:0] t;
    if (!sub) begin
      t = {2'b00, a} + {2'b00, b};
      if (t >= {2'b00, P}) t = t - {2'b00, P};
    end else if (a >= b) begin
      t = {2'b00, a} - {2'b00, b};
    end else begin
      t = {2'b00, a} + {2'b00, P} - {2'b00, b};
    end
    return t[254:0];
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [TAG_W-1:0] t,
                       input logic [254:0] a, input logic [254:0] b);
    inValid = v; inSub = s; inTag = t; inA = a; inB = b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: operations presented under reset never emerge
    drive(1'b1, 1'b0, 6'h3F, 255'd1, 255'd2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 reset valid", {255'd0, outValid}, 256'd0);
    end
    rst = 1'b0;
    drive(1'b0, 1'b0, '0, '0, '0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 post-reset idle", {255'd0, outValid}, 256'd0);
    end

    // R1 R2 R3 R5 R6 R9: back-to-back table walk, result 3 cycles after drive
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk("R5 valid", {255'd0, outValid}, 256'd1);
        chk("R6 tag", {250'd0, outTag}, {250'd0, TAG_W'(i - 3 + 1)});
        chk("R2 data", {1'b0, outData},
            {1'b0, refOp(VEC_A[i-3], VEC_B[i-3], VEC_SUB[i-3])});
        chk("R3 canonical", {255'd0, outData < P}, 256'd1);
      end
      if (i < NV) drive(1'b1, VEC_SUB[i], TAG_W'(i + 1), VEC_A[i], VEC_B[i]);
      else        drive(1'b0, 1'b0, '0, '0, '0);
    end

    // R9 wrap points stated explicitly
    chk("R9 a+b=p", {1'b0, refOp(P - 255'd1, 255'd1, 1'b0)}, 256'd0);
    chk("R9 2^255", {1'b0, refOp(255'd1 << 254, 255'd1 << 254, 1'b0)}, 256'd19);
    // R1: limb 1 borrow into limb 0 gives all ones in limb 0
    chk("R1 limb order", {1'b0, refOp(255'd1 << 17, 255'd1, 1'b1)}, 256'h1FFFF);

    // R4: isolated op, valid only on the third falling edge
    @(negedge clk);
    drive(1'b1, 1'b1, 6'h15, 255'd9, 255'd4);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1) drive(1'b0, 1'b0, '0, '0, '0);
      chk("R4 latency", {255'd0, outValid}, {255'd0, k == 3});
      if (k == 3) chk("R4 data", {1'b0, outData}, 256'd5);
    end

    // R7: bubble pattern reappears shifted by three
    begin
      logic pat [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        if (i >= 3) begin
          chk("R7 bubble valid", {255'd0, outValid}, {255'd0, pat[i-3]});
          if (pat[i-3]) begin
            chk("R7 bubble tag", {250'd0, outTag}, {250'd0, TAG_W'(32 + i - 3)});
            chk("R7 bubble data", {1'b0, outData}, {1'b0, refOp(P - 255'd2, 255'(i), 1'b0)});
          end
        end
        if (i < 6) drive(pat[i], 1'b0, TAG_W'(32 + i), P - 255'd2, 255'(i + 3));
        else       drive(1'b0, 1'b0, '0, '0, '0);
      end
    end

    // R8: reset while an op is in flight drops it
    @(negedge clk);
    drive(1'b1, 1'b0, 6'h2A, 255'd1, 255'd1);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0, '0);
    rst = 1'b1;
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk("R8 flush", {255'd0, outValid}, 256'd0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk("R8 flush after", {255'd0, outValid}, 256'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule